// File: doc/BRIEF.md
# Arbitrated dual-port RAM

A word-addressed memory with two independent access ports, named left and right. Each port has its own address, write data, read data, port enable, output enable, write strobe and one enable per byte lane, so either side can read or write at its own pace. Both sides may read the same word in the same cycle with no penalty. When both ports reach the same word and at least one of them writes, an arbiter picks a winner and drives an active-low busy flag to the other port. The losing port's write is dropped.

A mode strap chooses the busy direction. With the strap high the device is a master: its arbiter drives both busy outputs. With the strap low the device is a slave: its busy outputs are held inactive, and busy inputs from a master device block its writes instead. This lets several devices share one arbitration decision when they are placed side by side to build a wider word.

The model is synchronous to a single clock and takes one request per port per cycle. The default depth is reduced to keep elaboration small; setting the address-width parameter to 14 gives the full 16K-word array.

Top module: `dpram_arb`

## Requirements
- R1: During and right after reset, both read-valid flags are low, both read-data buses are zero, and both busy outputs are high.
- R2: A write from an enabled, unblocked port changes only the byte lanes whose enable bit is 1. Lane k is data bits 8k+7 down to 8k, and enable bit k selects lane k.
- R3: A read is a cycle with the port enabled, output enabled and not writing. One cycle later read-valid is 1 and read data holds the addressed word as it was before any write in the request cycle, with disabled lanes zero.
- R4: In any other cycle the port's read-valid is 0 and its read data is zero one cycle later. A disabled port writes nothing, even with its write strobe high.
- R5: Two ports reading the same address in the same cycle both receive the word, and neither busy output is asserted.
- R6: In master mode, a collision is both ports enabled on the same address with at least one writing. The losing port's busy output goes low in that same cycle, its write is dropped, and at most one busy output is ever low.
- R7: The winner of a collision is the port that already held its enable and address in the previous cycle while the other just arrived. If both arrive together, or neither does, left wins. A collision continuing on the same address keeps its winner.
- R8: In slave mode, both busy outputs stay high, local collisions block nothing, and a low busy input drops that port's write.
- R9: In slave mode, if both ports write the same address unblocked, the left port's data wins in each lane both enable, and each port's other enabled lanes are written.
- R10: Busy outputs always carry a driven 0 or 1, never an unknown value.
- R11: In master mode the busy inputs have no effect on writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| masterMode | input | 1 | 1: drive busy outputs; 0: take busy inputs |
| lEn | input | 1 | Left port enable |
| lWr | input | 1 | Left write strobe |
| lOutEn | input | 1 | Left output enable |
| lByteEn | input | LANES | Left byte-lane enables |
| lAddr | input | ADDR_W | Left address |
| lWdata | input | DATA_W | Left write data |
| lRdata | output | DATA_W | Left read data, zero when not valid |
| lRvalid | output | 1 | Left read data valid |
| lBusyN | output | 1 | Left busy, active low |
| lBusyInN | input | 1 | Left busy from a master, active low |
| rEn | input | 1 | Right port enable |
| rWr | input | 1 | Right write strobe |
| rOutEn | input | 1 | Right output enable |
| rByteEn | input | LANES | Right byte-lane enables |
| rAddr | input | ADDR_W | Right address |
| rWdata | input | DATA_W | Right write data |
| rRdata | output | DATA_W | Right read data, zero when not valid |
| rRvalid | output | 1 | Right read data valid |
| rBusyN | output | 1 | Right busy, active low |
| rBusyInN | input | 1 | Right busy from a master, active low |

## Verification
The assertions check on every cycle that the busy outputs are never unknown and never both low, that slave mode keeps them high, that read-read sharing raises no busy, that an ongoing collision keeps its winner, and that read data is zero when it is not valid, with disabled lanes zero when it is. The bench scenarios show the effects the assertions cannot: first-arrival ordering, reads that return pre-write data, dropped writes from losing or disabled ports, and lane merging when a slave takes both writes. These only show up in data read back later.

// File: rtl/dpr_pkg.sv
`timescale 1ns/1ps
package dpr_pkg;

  // Strobes handed from arbitration control to the storage datapath.
  typedef struct packed {
    logic wrL;  // left write allowed this cycle
    logic wrR;  // right write allowed this cycle
    logic rdL;  // left read requested this cycle
    logic rdR;  // right read requested this cycle
  } dprStrobe_t;

endpackage

// File: rtl/dpr_arbiter.sv
`timescale 1ns/1ps
module dpr_arbiter
  import dpr_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              masterMode,
  input  logic              lEn,
  input  logic              lWr,
  input  logic              lOutEn,
  input  logic [ADDR_W-1:0] lAddr,
  input  logic              lBusyInN,
  input  logic              rEn,
  input  logic              rWr,
  input  logic              rOutEn,
  input  logic [ADDR_W-1:0] rAddr,
  input  logic              rBusyInN,
  output dprStrobe_t        strobes,
  output logic              lBusyN,
  output logic              rBusyN
);

  // History of the previous cycle's requests.
  logic              lPrevEn, rPrevEn;
  logic [ADDR_W-1:0] lPrevAddr, rPrevAddr;
  logic              prevColl;
  logic [ADDR_W-1:0] prevCollAddr;
  logic              prevLeftWon;
  logic              armed;

  logic sameAddr, collide, lNew, rNew, leftWins;
  logic lLose, rLose, lBlock, rBlock;

  // A collision needs both ports on one word with a writer involved.
  assign sameAddr = (lAddr == rAddr);
  assign collide  = masterMode & lEn & rEn & sameAddr & (lWr | rWr);

  // A port is new when it was not on this word in the previous cycle.
  assign lNew = !(lPrevEn && (lPrevAddr == lAddr));
  assign rNew = !(rPrevEn && (rPrevAddr == rAddr));

  always_comb begin
    if (prevColl && (prevCollAddr == lAddr)) begin
      leftWins = prevLeftWon;           // ongoing collision keeps its winner
    end else if (lNew && !rNew) begin
      leftWins = 1'b0;                  // right was there first
    end else begin
      leftWins = 1'b1;                  // left first, or a tie
    end
  end

  assign lLose = collide & !leftWins;
  assign rLose = collide & leftWins;

  // Busy is pushed out only by a master; a slave keeps it released.
  assign lBusyN = masterMode ? !lLose : 1'b1;
  assign rBusyN = masterMode ? !rLose : 1'b1;

  // Write blocking comes from local arbitration or from the master.
  assign lBlock = masterMode ? lLose : !lBusyInN;
  assign rBlock = masterMode ? rLose : !rBusyInN;

  always_comb begin
    strobes.wrL = lEn & lWr & !lBlock;
    strobes.wrR = rEn & rWr & !rBlock;
    strobes.rdL = lEn & lOutEn & !lWr;
    strobes.rdR = rEn & rOutEn & !rWr;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lPrevEn      <= 1'b0;
      rPrevEn      <= 1'b0;
      lPrevAddr    <= '0;
      rPrevAddr    <= '0;
      prevColl     <= 1'b0;
      prevCollAddr <= '0;
      prevLeftWon  <= 1'b1;
      armed        <= 1'b0;
    end else begin
      lPrevEn      <= lEn;
      rPrevEn      <= rEn;
      lPrevAddr    <= lAddr;
      rPrevAddr    <= rAddr;
      prevColl     <= collide;
      prevCollAddr <= lAddr;
      prevLeftWon  <= leftWins;
      armed        <= 1'b1;
    end
  end

  // R10: busy outputs are always driven to a known level.
  p_busy_known_r10: assert property (@(posedge clk) disable iff (!rstN)
    !$isunknown({lBusyN, rBusyN}));

  // R6: at most one port loses.
  p_single_loser_r6: assert property (@(posedge clk) disable iff (!rstN)
    lBusyN || rBusyN);

  // R8: a slave never asserts its own busy outputs.
  p_slave_quiet_r8: assert property (@(posedge clk) disable iff (!rstN)
    !masterMode |-> (lBusyN && rBusyN));

  // R8: an external busy drops the slave's writes.
  p_slave_block_r8: assert property (@(posedge clk) disable iff (!rstN)
    (!masterMode && !lBusyInN) |-> !strobes.wrL);

  // R5: shared reads never raise busy.
  p_read_share_r5: assert property (@(posedge clk) disable iff (!rstN)
    (lEn && rEn && sameAddr && !lWr && !rWr) |-> (lBusyN && rBusyN));

  // R7: a collision held on the same word keeps the same loser.
  p_held_winner_r7: assert property (@(posedge clk) disable iff (!rstN)
    (armed && collide && $past(collide) && (lAddr == $past(lAddr)))
      |-> ((lBusyN == $past(lBusyN)) && (rBusyN == $past(rBusyN))));

  // R6: a losing master-mode port never writes.
  p_loser_no_write_r6: assert property (@(posedge clk) disable iff (!rstN)
    (masterMode && !rBusyN) |-> !strobes.wrR);

  logic unusedOe;
  assign unusedOe = lOutEn & rOutEn & 1'b0;

endmodule

// File: rtl/dpr_store.sv
`timescale 1ns/1ps
module dpr_store
  import dpr_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  dprStrobe_t        strobes,
  input  logic [ADDR_W-1:0] lAddr,
  input  logic [ADDR_W-1:0] rAddr,
  input  logic [DATA_W/8-1:0] lByteEn,
  input  logic [DATA_W/8-1:0] rByteEn,
  input  logic [DATA_W-1:0] lWdata,
  input  logic [DATA_W-1:0] rWdata,
  output logic [DATA_W-1:0] lRdata,
  output logic [DATA_W-1:0] rRdata,
  output logic              lRvalid,
  output logic              rRvalid
);

  localparam int LANES = DATA_W / 8;
  localparam int DEPTH = 1 << ADDR_W;
  localparam int PORTS = 2;

  logic [DATA_W-1:0] mem [DEPTH];

  // Port-indexed views: index 0 is left, 1 is right.
  logic [ADDR_W-1:0] pAddr   [PORTS];
  logic [LANES-1:0]  pBe     [PORTS];
  logic              pRd     [PORTS];
  logic [DATA_W-1:0] pMask   [PORTS];
  logic [DATA_W-1:0] pRdReg  [PORTS];
  logic              pVldReg [PORTS];

  always_comb begin
    pAddr[0] = lAddr;
    pAddr[1] = rAddr;
    pBe[0]   = lByteEn;
    pBe[1]   = rByteEn;
    pRd[0]   = strobes.rdL;
    pRd[1]   = strobes.rdR;
  end

  // Byte-lane writes; left is applied last so it wins a shared lane.
  always_ff @(posedge clk) begin
    for (int k = 0; k < LANES; k++) begin
      if (strobes.wrR && rByteEn[k]) mem[rAddr][k*8 +: 8] <= rWdata[k*8 +: 8];
      if (strobes.wrL && lByteEn[k]) mem[lAddr][k*8 +: 8] <= lWdata[k*8 +: 8];
    end
  end

  for (genvar p = 0; p < PORTS; p++) begin : g_port
    always_comb begin
      for (int k = 0; k < LANES; k++) begin
        pMask[p][k*8 +: 8] = {8{pBe[p][k]}};
      end
    end

    // Read-first: the register captures the word before this cycle's write.
    always_ff @(posedge clk) begin
      if (!rstN) begin
        pRdReg[p]  <= '0;
        pVldReg[p] <= 1'b0;
      end else if (pRd[p]) begin
        pRdReg[p]  <= mem[pAddr[p]] & pMask[p];
        pVldReg[p] <= 1'b1;
      end else begin
        pRdReg[p]  <= '0;
        pVldReg[p] <= 1'b0;
      end
    end

    // R4: output is zero whenever it is not valid.
    p_idle_zero_r4: assert property (@(posedge clk) disable iff (!rstN)
      !pVldReg[p] |-> (pRdReg[p] == '0));

    // R4: valid data only follows a read request.
    p_valid_after_req_r4: assert property (@(posedge clk) disable iff (!rstN)
      pVldReg[p] |-> $past(pRd[p]));

    // R3: lanes not enabled in the request read as zero.
    p_lane_zero_r3: assert property (@(posedge clk) disable iff (!rstN)
      pVldReg[p] |-> ((pRdReg[p] & ~$past(pMask[p])) == '0));
  end

  assign lRdata  = pRdReg[0];
  assign rRdata  = pRdReg[1];
  assign lRvalid = pVldReg[0];
  assign rRvalid = pVldReg[1];

endmodule

// File: rtl/dpram_arb.sv
`timescale 1ns/1ps
module dpram_arb
  import dpr_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 16,
  parameter int LANES  = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              masterMode,
  input  logic              lEn,
  input  logic              lWr,
  input  logic              lOutEn,
  input  logic [LANES-1:0]  lByteEn,
  input  logic [ADDR_W-1:0] lAddr,
  input  logic [DATA_W-1:0] lWdata,
  output logic [DATA_W-1:0] lRdata,
  output logic              lRvalid,
  output logic              lBusyN,
  input  logic              lBusyInN,
  input  logic              rEn,
  input  logic              rWr,
  input  logic              rOutEn,
  input  logic [LANES-1:0]  rByteEn,
  input  logic [ADDR_W-1:0] rAddr,
  input  logic [DATA_W-1:0] rWdata,
  output logic [DATA_W-1:0] rRdata,
  output logic              rRvalid,
  output logic              rBusyN,
  input  logic              rBusyInN
);

  dprStrobe_t strobes;

  dpr_arbiter #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .masterMode (masterMode),
    .lEn        (lEn),
    .lWr        (lWr),
    .lOutEn     (lOutEn),
    .lAddr      (lAddr),
    .lBusyInN   (lBusyInN),
    .rEn        (rEn),
    .rWr        (rWr),
    .rOutEn     (rOutEn),
    .rAddr      (rAddr),
    .rBusyInN   (rBusyInN),
    .strobes    (strobes),
    .lBusyN     (lBusyN),
    .rBusyN     (rBusyN)
  );

  dpr_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_data (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .lAddr   (lAddr),
    .rAddr   (rAddr),
    .lByteEn (lByteEn),
    .rByteEn (rByteEn),
    .lWdata  (lWdata),
    .rWdata  (rWdata),
    .lRdata  (lRdata),
    .rRdata  (rRdata),
    .lRvalid (lRvalid),
    .rRvalid (rRvalid)
  );

endmodule

// File: tb/test_dpram_arb.sv
`timescale 1ns/1ps
module test_dpram_arb;

  localparam int AW = 10;
  localparam int DW = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic masterMode, lEn, lWr, lOutEn, lBusyInN, rEn, rWr, rOutEn, rBusyInN;
  logic [1:0] lByteEn, rByteEn;
  logic [AW-1:0] lAddr, rAddr;
  logic [DW-1:0] lWdata, rWdata, lRdata, rRdata;
  logic lRvalid, rRvalid, lBusyN, rBusyN;

  always #2.5 clk = ~clk;

  dpram_arb #(.ADDR_W(AW), .DATA_W(DW)) i_dpram_arb (.*);

  int checks = 0;
  int fails = 0;
  bit done = 0;

  // Bench model state.
  logic [15:0] mdl [8];
  logic pEnL = 0, pEnR = 0, pColl = 0, pWinL = 1;
  logic [AW-1:0] pAL = '0, pAR = '0, pCollA = '0;
  logic expVL = 0, expVR = 0;
  logic [15:0] expDL = '0, expDR = '0;
  string prevTag = "R1";

  function automatic logic [15:0] laneMask(input logic [1:0] be);
    return {{8{be[1]}}, {8{be[0]}}};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle();
    masterMode = 1; lEn = 0; lWr = 0; lOutEn = 0; lByteEn = 0; lAddr = 0; lWdata = 0;
    lBusyInN = 1; rEn = 0; rWr = 0; rOutEn = 0; rByteEn = 0; rAddr = 0; rWdata = 0;
    rBusyInN = 1;
  endtask

  // One cycle: check last cycle's reads, apply inputs held in the stimulus
  // variables, check busy, then update the model at the clock edge.
  logic sEnL, sWrL, sOeL, sEnR, sWrR, sOeR, sMst, sBiL, sBiR;
  logic [1:0] sBeL, sBeR;
  logic [AW-1:0] sAL, sAR;
  logic [15:0] sDL, sDR;

  task automatic step(input string tag);
    logic coll, newL, newR, winL, wEffL, wEffR;
    string btag;
    @(negedge clk);
    chk({prevTag, " left valid"}, lRvalid, expVL);
    chk({prevTag, " left data"}, lRdata, expDL);
    chk({prevTag, " right valid"}, rRvalid, expVR);
    chk({prevTag, " right data"}, rRdata, expDR);
    masterMode = sMst; lEn = sEnL; lWr = sWrL; lOutEn = sOeL; lByteEn = sBeL;
    lAddr = sAL; lWdata = sDL; lBusyInN = sBiL;
    rEn = sEnR; rWr = sWrR; rOutEn = sOeR; rByteEn = sBeR; rAddr = sAR;
    rWdata = sDR; rBusyInN = sBiR;
    #1;
    coll = sMst && sEnL && sEnR && (sAL == sAR) && (sWrL || sWrR);
    newL = !(pEnL && pAL == sAL);
    newR = !(pEnR && pAR == sAR);
    if (pColl && pCollA == sAL) winL = pWinL;
    else if (newL && !newR) winL = 0;
    else winL = 1;
    btag = !sMst ? "R8" : (coll ? "R7" : "R6");
    chk({btag, " left busy"}, lBusyN, (sMst && coll && !winL) ? 1'b0 : 1'b1);
    chk({btag, " right busy"}, rBusyN, (sMst && coll && winL) ? 1'b0 : 1'b1);
    chk("R10 busy driven", $isunknown({lBusyN, rBusyN}), 1'b0);
    expVL = sEnL && sOeL && !sWrL;
    expDL = expVL ? (mdl[sAL[2:0]] & laneMask(sBeL)) : 16'h0;
    expVR = sEnR && sOeR && !sWrR;
    expDR = expVR ? (mdl[sAR[2:0]] & laneMask(sBeR)) : 16'h0;
    prevTag = tag;
    if (sMst) begin
      wEffL = sEnL && sWrL && !(coll && !winL);
      wEffR = sEnR && sWrR && !(coll && winL);
    end else begin
      wEffL = sEnL && sWrL && sBiL;
      wEffR = sEnR && sWrR && sBiR;
    end
    @(posedge clk);
    if (wEffR) mdl[sAR[2:0]] = (mdl[sAR[2:0]] & ~laneMask(sBeR)) | (sDR & laneMask(sBeR));
    if (wEffL) mdl[sAL[2:0]] = (mdl[sAL[2:0]] & ~laneMask(sBeL)) | (sDL & laneMask(sBeL));
    pEnL = sEnL; pEnR = sEnR; pAL = sAL; pAR = sAR;
    pColl = coll; pCollA = sAL; pWinL = winL;
  endtask

  task automatic sIdle();
    sMst = 1; sEnL = 0; sWrL = 0; sOeL = 0; sBeL = 0; sAL = 0; sDL = 0; sBiL = 1;
    sEnR = 0; sWrR = 0; sOeR = 0; sBeR = 0; sAR = 0; sDR = 0; sBiR = 1;
  endtask

  task automatic sLeft(input logic en, input logic wr, input logic oe,
                       input logic [1:0] be, input int a, input logic [15:0] d);
    sEnL = en; sWrL = wr; sOeL = oe; sBeL = be; sAL = AW'(a); sDL = d;
  endtask

  task automatic sRight(input logic en, input logic wr, input logic oe,
                        input logic [1:0] be, input int a, input logic [15:0] d);
    sEnR = en; sWrR = wr; sOeR = oe; sBeR = be; sAR = AW'(a); sDR = d;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    idle();
    sIdle();
    repeat (3) @(negedge clk);
    chk("R1 busy during reset", {lBusyN, rBusyN}, 2'b11);
    rstN = 1'b1;
    #1;
    chk("R1 left valid", lRvalid, 1'b0);
    chk("R1 left data", lRdata, 16'h0);
    chk("R1 right valid", rRvalid, 1'b0);
    chk("R1 right data", rRdata, 16'h0);
    chk("R1 busy", {lBusyN, rBusyN}, 2'b11);
    @(posedge clk);

    // Fill addresses 0..7 from the left.
    for (int a = 0; a < 8; a++) begin
      sIdle(); sLeft(1, 1, 0, 2'b11, a, 16'h1100 + 16'(a * 16'h0101));
      step("R2");
    end
    // Shared read of one word.
    sIdle(); sLeft(1, 0, 1, 2'b11, 3, 0); sRight(1, 0, 1, 2'b11, 3, 0);
    step("R5");
    // Lower-lane write then full and upper-only reads.
    sIdle(); sLeft(1, 1, 0, 2'b01, 2, 16'hAAAA); step("R2");
    sIdle(); sLeft(1, 0, 1, 2'b11, 2, 0); step("R2");
    sIdle(); sRight(1, 0, 1, 2'b10, 2, 0); step("R3");
    // Read-first: left writes while right reads the same word.
    sIdle(); sLeft(1, 1, 0, 2'b11, 4, 16'hBEEF); sRight(1, 0, 1, 2'b11, 4, 0);
    step("R3");
    sIdle(); sRight(1, 0, 1, 2'b11, 4, 0); step("R3");
    // Disabled write and output disabled read.
    sIdle(); sLeft(0, 1, 1, 2'b11, 5, 16'hDEAD); step("R4");
    sIdle(); sLeft(1, 0, 0, 2'b11, 5, 0); sRight(1, 0, 1, 2'b11, 5, 0); step("R4");
    // Tie: both arrive writing one word; left wins and holds.
    sIdle(); sLeft(1, 1, 0, 2'b11, 6, 16'h6161); sRight(1, 1, 0, 2'b11, 6, 16'h6262);
    step("R7");
    step("R7");
    sIdle(); sRight(1, 0, 1, 2'b11, 6, 0); step("R6");
    // Right arrives first; left arrives writing and loses.
    sIdle(); sRight(1, 0, 1, 2'b11, 1, 0); step("R7");
    sLeft(1, 1, 0, 2'b11, 1, 16'h7777); step("R7");
    step("R7");
    sIdle(); sLeft(1, 0, 1, 2'b11, 1, 0); step("R6");
    // Slave: busy input drops right write; merged lanes.
    sIdle(); sMst = 0; sLeft(1, 1, 0, 2'b11, 7, 16'h1234); sRight(1, 1, 0, 2'b11, 0, 16'h5678);
    sBiL = 1; sBiR = 0; step("R8");
    sIdle(); sMst = 0; sLeft(1, 1, 0, 2'b01, 7, 16'hAABB); sRight(1, 1, 0, 2'b11, 7, 16'hCCDD);
    step("R9");
    sIdle(); sLeft(1, 0, 1, 2'b11, 7, 0); sRight(1, 0, 1, 2'b11, 0, 0); step("R9");
    // Master ignores busy inputs.
    sIdle(); sLeft(1, 1, 0, 2'b11, 0, 16'h0F0F); sBiL = 0; sBiR = 0; step("R11");
    sIdle(); sLeft(1, 0, 1, 2'b11, 0, 0); step("R11");

    // Constrained random traffic on a few words to provoke collisions.
    for (int i = 0; i < 4000; i++) begin
      sMst = ($urandom % 10) != 0;
      sEnL = ($urandom % 5) != 0; sWrL = ($urandom % 5) < 2; sOeL = ($urandom % 4) != 0;
      sBeL = 2'($urandom); sAL = AW'($urandom % 4); sDL = 16'($urandom); sBiL = ($urandom % 3) != 0;
      sEnR = ($urandom % 5) != 0; sWrR = ($urandom % 5) < 2; sOeR = ($urandom % 4) != 0;
      sBeR = 2'($urandom); sAR = AW'($urandom % 4); sDR = 16'($urandom); sBiR = ($urandom % 3) != 0;
      step("R3");
    end
    sIdle(); step("R4");
    sIdle(); step("R4");

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule